// File: doc/BRIEF.md
# Bidirectional GPIO Port with Register Access

This block is a small general-purpose I/O port that sits on a byte-wide register bus. Two pins are served by three per-pin registers: an output latch, a direction register and a pulldown-enable register. Software sets a pin's direction bit to make it drive, and the pin then carries the latch bit. While a pin is an input, reading the latch address returns the pin's synchronised level and not the stored bit.

Pin levels reach the bus only through a two-flop synchroniser, so a read shows a pin change two clocks after it happens. Reset clears the direction and pulldown registers, which makes every pin an undriven input. The output latch has no reset: it keeps its contents across reset and is undefined after power-up. A write to the latch while a pin is an input is kept and shows on the pin when the pin is later switched to output. Reads are combinational and qualified by the read enable. Writes take effect at the clock edge.

Top module: `gpio_port`

## Requirements
- R1: While rst_ni is low and after it rises, pin_oe_o and pin_pd_o are 2'b00 and the direction and pulldown registers read 0x00.
- R2: Reset does not change the output latch: a value written before reset is driven again once the pin is set as output after reset, with no new write.
- R3: For each pin n, pin_oe_o[n] equals direction bit n. pin_out_o[n] equals latch bit n when the pin is an output and is 0 when it is an input.
- R4: A write to address 0x01 updates latch bits 1:0 whatever the directions. An input pin is not driven by it, and the stored bit appears on pin_out_o once the pin becomes an output.
- R5: A read of address 0x01 returns, in bit n of an input pin, the level pin_i[n] had two rising edges earlier.
- R6: A read of address 0x01 returns, in bit n of an output pin, latch bit n.
- R7: Bits 7:2 of every register read as 0, and the values written to those bits are discarded.
- R8: The direction register sits at address 0x05 and the pulldown register at 0x11. Each reads back its last written bits 1:0. Bit n of each register controls pin n.
- R9: A read of any address other than 0x01, 0x05 and 0x11 returns 0x00, and a write to such an address changes no register.
- R10: pin_pd_o[n] is 1 only when pulldown bit n is set and pin n is an input. It is 0 whenever the pin is an output.
- R11: rdata_o is 0x00 in any cycle where re_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write enable, sampled at the rising edge |
| re_i | input | 1 | Read enable, qualifies rdata_o in the same cycle |
| rdata_o | output | 8 | Read data |
| pin_i | input | 2 | Pin levels from the pads |
| pin_oe_o | output | 2 | Pin output enable |
| pin_out_o | output | 2 | Pin output value |
| pin_pd_o | output | 2 | Pin pulldown enable |

## Verification
Directed phases cover several cases: all pins as inputs with the pin levels toggling, a mix of input and output pins, both pins as outputs, and pins switched between directions after the latch was written. Comparing the mixed case with the all-input case shows whether the read path selects the live level or the latch for each bit. Toggling pins on consecutive cycles separates a two-clock lag from a one- or three-clock lag. Writes of 0xFF and writes to unmapped addresses expose any leak into the upper bits or into the wrong register. A reset in the middle of the run, followed by setting the pins as outputs, shows whether the latch survived reset. A final phase with random addresses, data and pin levels is checked against the reference model on every clock.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_PULL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int          NPINS     = 2,
  parameter int          AW        = 8,
  parameter int          DW        = 8,
  parameter logic [7:0]  ADDR_DATA = 8'h01,
  parameter logic [7:0]  ADDR_DIR  = 8'h05,
  parameter logic [7:0]  ADDR_PULL = 8'h11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             we_i,
  output reg_sel_e         sel_o,
  output logic [NPINS-1:0] data_o,
  output logic [NPINS-1:0] dir_o,
  output logic [NPINS-1:0] pull_o
);
  logic [NPINS-1:0] data_q, dir_q, pull_q;
  reg_sel_e         sel;

  always_comb begin
    sel = SEL_NONE;
    if (addr_i == AW'(ADDR_DATA))      sel = SEL_DATA;
    else if (addr_i == AW'(ADDR_DIR))  sel = SEL_DIR;
    else if (addr_i == AW'(ADDR_PULL)) sel = SEL_PULL;
  end

  // output latch deliberately has no reset
  always_ff @(posedge clk_i) begin
    if (we_i && sel == SEL_DATA) data_q <= wdata_i[NPINS-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      pull_q <= '0;
    end else if (we_i) begin
      if (sel == SEL_DIR)  dir_q  <= wdata_i[NPINS-1:0];
      if (sel == SEL_PULL) pull_q <= wdata_i[NPINS-1:0];
    end
  end

  assign sel_o  = sel;
  assign data_o = data_q;
  assign dir_o  = dir_q;
  assign pull_o = pull_q;
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_pkg::*;
#(
  parameter int NPINS = 2,
  parameter int DW    = 8
) (
  input  logic             re_i,
  input  reg_sel_e         sel_i,
  input  logic [NPINS-1:0] data_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic [NPINS-1:0] pull_i,
  input  logic [NPINS-1:0] pin_sync_i,
  output logic [DW-1:0]    rdata_o
);
  logic [NPINS-1:0] port_view;

  for (genvar n = 0; n < NPINS; n++) begin : g_view
    assign port_view[n] = dir_i[n] ? data_i[n] : pin_sync_i[n];
  end

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      unique case (sel_i)
        SEL_DATA: rdata_o[NPINS-1:0] = port_view;
        SEL_DIR:  rdata_o[NPINS-1:0] = dir_i;
        SEL_PULL: rdata_o[NPINS-1:0] = pull_i;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int          NPINS       = 2,
  parameter int          AW          = 8,
  parameter int          DW          = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  ADDR_DATA   = 8'h01,
  parameter logic [7:0]  ADDR_DIR    = 8'h05,
  parameter logic [7:0]  ADDR_PULL   = 8'h11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             we_i,
  input  logic             re_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_oe_o,
  output logic [NPINS-1:0] pin_out_o,
  output logic [NPINS-1:0] pin_pd_o
);
  reg_sel_e         sel;
  logic [NPINS-1:0] data_q, dir_q, pull_q, pin_sync;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  gpio_regs #(
    .NPINS(NPINS), .AW(AW), .DW(DW),
    .ADDR_DATA(ADDR_DATA), .ADDR_DIR(ADDR_DIR), .ADDR_PULL(ADDR_PULL)
  ) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .we_i    (we_i),
    .sel_o   (sel),
    .data_o  (data_q),
    .dir_o   (dir_q),
    .pull_o  (pull_q)
  );

  gpio_rdmux #(.NPINS(NPINS), .DW(DW)) i_rdmux (
    .re_i       (re_i),
    .sel_i      (sel),
    .data_i     (data_q),
    .dir_i      (dir_q),
    .pull_i     (pull_q),
    .pin_sync_i (pin_sync),
    .rdata_o    (rdata_o)
  );

  assign pin_oe_o  = dir_q;
  assign pin_out_o = data_q & dir_q;
  assign pin_pd_o  = pull_q & ~dir_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int          NPINS    = 2,
  parameter int          AW       = 8,
  parameter int          DW       = 8,
  parameter logic [7:0]  ADDR_DIR = 8'h05
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    addr_i,
  input logic             we_i,
  input logic             re_i,
  input logic [DW-1:0]    rdata_o,
  input logic [NPINS-1:0] pin_oe_o,
  input logic [NPINS-1:0] pin_out_o,
  input logic [NPINS-1:0] pin_pd_o
);
  a_r10_pd_off_when_driving: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_pd_o & pin_oe_o) == '0);

  a_r3_quiet_when_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_out_o & ~pin_oe_o) == '0);

  a_r7_upper_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o >> NPINS) == '0);

  a_r11_no_read_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |-> rdata_o == '0);

  a_r8_dir_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == AW'(ADDR_DIR)) |=> $stable(pin_oe_o));
endmodule

bind gpio_port gpio_port_chk #(
  .NPINS(NPINS), .AW(AW), .DW(DW), .ADDR_DIR(ADDR_DIR)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .re_i      (re_i),
  .rdata_o   (rdata_o),
  .pin_oe_o  (pin_oe_o),
  .pin_out_o (pin_out_o),
  .pin_pd_o  (pin_pd_o)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic       we = 1'b0;
  logic       re = 1'b0;
  logic [7:0] rdata;
  logic [1:0] pin = 2'b00;
  logic [1:0] oe, pout, pd;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_port i_gpio_port (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .pin_i(pin),
    .pin_oe_o(oe), .pin_out_o(pout), .pin_pd_o(pd)
  );

  // reference model
  logic [1:0] m_dir = 2'b00, m_pull = 2'b00, m_data = 2'b00, m_known = 2'b00;
  logic [1:0] hist[$] = '{2'b00, 2'b00};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir  <= 2'b00;
      m_pull <= 2'b00;
      hist    = '{2'b00, 2'b00};
    end else begin
      hist.push_front(pin);
      void'(hist.pop_back());
      if (we) begin
        if (addr == 8'h01) begin m_data <= wdata[1:0]; m_known <= 2'b11; end
        if (addr == 8'h05) m_dir  <= wdata[1:0];
        if (addr == 8'h11) m_pull <= wdata[1:0];
      end
    end
  end
  // latch bits survive reset in the model too (R2)
  always @(posedge clk) if (!rst_n && we && addr == 8'h01) begin
    m_data <= wdata[1:0]; m_known <= 2'b11;
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp, logic [7:0] mask);
    n_chk++;
    if ((act & mask) != (exp & mask)) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h (mask %02h) at cycle %0d",
               tag, act, exp, mask, cycles);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    logic [7:0] e_rd, m_rd;
    string      tag;
    cycles++;
    chk(rst_n ? "R3 oe" : "R1 oe", {6'b0, oe}, {6'b0, m_dir}, 8'hFF);
    chk("R3 out", {6'b0, pout}, {6'b0, m_dir & m_data}, {6'b0, ~m_dir | m_known});
    chk(rst_n ? "R10 pd" : "R1 pd", {6'b0, pd}, {6'b0, m_pull & ~m_dir}, 8'hFF);
    e_rd = 8'h00; m_rd = 8'hFF; tag = "R11 idle";
    if (re) begin
      case (addr)
        8'h01: begin
          for (int n = 0; n < 2; n++) begin
            e_rd[n] = m_dir[n] ? m_data[n] : hist[1][n];
            if (m_dir[n] && !m_known[n]) m_rd[n] = 1'b0;
          end
          tag = (m_dir == 2'b00) ? "R5 data" : "R6 data";
        end
        8'h05: begin e_rd = {6'b0, m_dir};  tag = "R8 dir";  end
        8'h11: begin e_rd = {6'b0, m_pull}; tag = "R8 pull"; end
        default: tag = "R9 unmapped";
      endcase
    end
    chk(tag, rdata, e_rd, m_rd);
    chk("R7 upper", {2'b0, rdata[7:2]}, 8'h00, 8'hFF);
  end

  always @(posedge clk) if (cycles > 100000 && !done) begin
    done = 1;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic step(logic [7:0] a, logic [7:0] d, logic w, logic r, logic [1:0] p);
    @(negedge clk);
    #1;
    addr = a; wdata = d; we = w; re = r; pin = p;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step(8'h00, 8'h00, 1'b0, 1'b0, pin);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    step(8'h05, 8'h00, 0, 1, 2'b00);
    step(8'h11, 8'h00, 0, 1, 2'b00);
    // R5: all inputs, pins toggling each cycle, read data reg
    step(8'h01, 8'h00, 0, 1, 2'b01);
    step(8'h01, 8'h00, 0, 1, 2'b10);
    step(8'h01, 8'h00, 0, 1, 2'b11);
    step(8'h01, 8'h00, 0, 1, 2'b00);
    step(8'h01, 8'h00, 0, 1, 2'b01);
    step(8'h01, 8'h00, 0, 1, 2'b01);
    step(8'h01, 8'h00, 0, 1, 2'b01);
    // R4: write latch while inputs; pins not driven
    step(8'h01, 8'hFE, 1, 0, 2'b01);
    step(8'h01, 8'h00, 0, 1, 2'b01);
    step(8'h01, 8'h00, 0, 1, 2'b01);
    // R6/R4: pin1 output shows latched 1, pin0 stays live input
    step(8'h05, 8'h02, 1, 0, 2'b00);
    step(8'h01, 8'h00, 0, 1, 2'b00);
    step(8'h01, 8'h00, 0, 1, 2'b01);
    step(8'h01, 8'h00, 0, 1, 2'b01);
    step(8'h01, 8'h00, 0, 1, 2'b01);
    // R7: upper bits dropped, both outputs
    step(8'h05, 8'hFF, 1, 0, 2'b00);
    step(8'h05, 8'h00, 0, 1, 2'b00);
    step(8'h01, 8'hFD, 1, 1, 2'b00);
    step(8'h01, 8'h00, 0, 1, 2'b10);
    // R10: pulldown gated by direction
    step(8'h11, 8'hFF, 1, 0, 2'b10);
    step(8'h11, 8'h00, 0, 1, 2'b10);
    step(8'h05, 8'h01, 1, 0, 2'b10);
    step(8'h11, 8'h00, 0, 1, 2'b10);
    step(8'h05, 8'h00, 1, 0, 2'b10);
    step(8'h11, 8'h02, 1, 1, 2'b10);
    idle(2);
    // R9: unmapped writes and reads
    step(8'h00, 8'hFF, 1, 1, 2'b11);
    step(8'h02, 8'hFF, 1, 1, 2'b11);
    step(8'h15, 8'hFF, 1, 1, 2'b11);
    step(8'hFF, 8'hFF, 1, 1, 2'b11);
    step(8'h06, 8'h00, 0, 1, 2'b11);
    step(8'h05, 8'h00, 0, 1, 2'b11);
    step(8'h11, 8'h00, 0, 1, 2'b11);
    step(8'h01, 8'h00, 0, 1, 2'b11);
    // R2: latch survives reset
    step(8'h01, 8'h01, 1, 0, 2'b00);
    step(8'h05, 8'h03, 1, 0, 2'b00);
    idle(1);
    @(negedge clk); #2 rst_n = 1'b0;
    idle(2);
    @(negedge clk); #2 rst_n = 1'b1;
    step(8'h05, 8'h00, 0, 1, 2'b00);
    step(8'h05, 8'h03, 1, 0, 2'b00);
    step(8'h01, 8'h00, 0, 1, 2'b00);
    idle(1);
    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      case ($urandom_range(0, 3))
        0: a = 8'h01;
        1: a = 8'h05;
        2: a = 8'h11;
        default: a = 8'($urandom);
      endcase
      step(a, 8'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
    end
    idle(2);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule